// File: doc/BRIEF.md
# Multi-Granule Memory Tag Checker

This block decides whether a memory access may proceed under a lock-and-key tagging scheme. Each 16-byte granule of memory carries a 4-bit allocation tag, and each pointer carries a 4-bit key in its upper address bits. A request gives a start address, the access size minus one, and a flag that says whether the pointer is subject to checking. The block works out which granules the access touches. It fetches their tags from a packed tag store and compares each one against the pointer key. It returns pass, fail or unchecked, and on a failure it also returns the faulting address.

The tag store is reached through a plain synchronous read port with one cycle of latency. Each byte of the store holds the tags of two neighbouring granules. The block reads at most one tag byte per cycle, so one cycle can cover up to two granules. A scan can begin on either half of a byte. It stops at the first mismatching granule. A new request is taken only while the block is idle, and every request ends with a one-cycle completion strobe.

Top module: `tag_granule_checker`

## Requirements
- R1: `req_ready` is high exactly when no checked scan is in progress, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. After reset `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0.
- R2: A request taken with `req_chk_en` = 0 gives `done` = 1, `unchecked` = 1, `fail` = 0 one cycle later and issues no tag read, whatever the tag store holds.
- R3: The first tag read of a checked request uses byte index `req_addr >> 5`. Each later read of that request uses the next index (modulo the port width), and at most one read is issued per cycle.
- R4: The granule whose address has bit 4 = 0 is compared with bits 3:0 of its tag byte. The granule with bit 4 = 1 is compared with bits 7:4. A scan whose start address has bit 4 = 1 begins at bits 7:4 of the first byte.
- R5: The pointer key is bits 59:56 of `req_addr`.
- R6: The granules checked run from `req_addr` rounded down to 16 through (`req_addr` + `req_size_m1`) rounded down to 16, inclusive. When all of them match, the result is `fail` = 0, `unchecked` = 0.
- R7: When the first granule mismatches, `fault_addr` equals `req_addr` exactly, with its low bits and key bits unchanged.
- R8: When granule n (n ≥ 1, counted from the first) is the first to mismatch, `fault_addr` equals the first granule base plus n×16.
- R9: Checking stops at the first mismatch. A later mismatch in the same access does not change the reported fault address.
- R10: `done` lasts one cycle, `fail` and `unchecked` are never both 1, and `fault_addr` is 0 whenever `done` is 1 and `fail` is 0.
- R11: An access that passes issues exactly one read per tag byte it spans, which is (last granule >> 1) − (first granule >> 1) + 1 reads, with granules counted in 16-byte units.
- R12: Nibbles of a tag byte that belong to granules outside the access never cause a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Access start address, key in bits 59:56 |
| req_size_m1 | input | SIZE_W | Access size in bytes minus one |
| req_chk_en | input | 1 | 1 = tag check applies to this pointer |
| mem_rd_en | output | 1 | Tag byte read strobe |
| mem_addr | output | TAG_AW | Tag byte index |
| mem_rdata | input | 8 | Tag byte, valid the cycle after the read |
| done | output | 1 | Result strobe |
| fail | output | 1 | Tag mismatch found (valid with done) |
| unchecked | output | 1 | Access bypassed checking (valid with done) |
| fault_addr | output | ADDR_W | Faulting address (valid with done and fail) |

## Verification
The embedded assertions check the handshake rules and the shape of the result on every cycle. They confirm that a strobe lasts one cycle, that the outcome flags never clash, that the fault address is cleared on success, that reads happen only while busy and advance one index at a time, and that the bypass path answers in one cycle without touching memory. The bench scenarios are the only way to show the functional results: the choice of nibble for odd and even starts, the granule count, the two forms of the fault address, stopping at the first mismatch, and the read count per access. For these, the bench fills the tag store with chosen patterns and compares each outcome against a model of the requirements.

// File: rtl/tag_granule_checker.sv
module tag_granule_checker #(
  parameter int ADDR_W  = 64,
  parameter int SIZE_W  = 12,
  parameter int TAG_AW  = 16,
  parameter int KEY_LSB = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size_m1,
  input  logic              req_chk_en,
  output logic              mem_rd_en,
  output logic [TAG_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              fail,
  output logic              unchecked,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int CNT_W = SIZE_W - 2;

  typedef enum logic {S_IDLE, S_SCAN} state_t;
  state_t state;

  logic [ADDR_W-1:0] start_q, base_q;
  logic [3:0]        key_q;
  logic              odd_q, dvld_q;
  logic [CNT_W-1:0]  left_q, seen_q, rd_left_q;
  logic [TAG_AW-1:0] rd_ptr_q;

  wire [ADDR_W-1:0] first_g = {req_addr[ADDR_W-1:4], 4'b0};
  wire [ADDR_W-1:0] end_b   = req_addr + ADDR_W'(req_size_m1);
  wire [ADDR_W-1:0] last_g  = {end_b[ADDR_W-1:4], 4'b0};
  wire [ADDR_W-1:0] g_diff  = (last_g - first_g) >> 4;
  wire [ADDR_W-1:0] b_diff  = (last_g >> 5) - (first_g >> 5);
  wire [CNT_W-1:0]  g_init  = CNT_W'(g_diff) + CNT_W'(1);
  wire [CNT_W-1:0]  b_init  = CNT_W'(b_diff) + CNT_W'(1);

  assign req_ready = (state == S_IDLE);
  assign mem_rd_en = (state == S_SCAN) && (rd_left_q != '0);
  assign mem_addr  = rd_ptr_q;

  wire             use_lo  = !odd_q;
  wire             use_hi  = odd_q || (left_q != CNT_W'(1));
  wire             lo_bad  = use_lo && (mem_rdata[3:0] != key_q);
  wire             hi_bad  = use_hi && (mem_rdata[7:4] != key_q);
  wire [CNT_W-1:0] take    = (use_lo && use_hi) ? CNT_W'(2) : CNT_W'(1);
  wire [CNT_W-1:0] mis_n   = (lo_bad || !use_lo) ? seen_q : seen_q + CNT_W'(1);
  wire             miss    = dvld_q && (lo_bad || hi_bad);
  wire             fin     = dvld_q && (left_q == take);
  wire [ADDR_W-1:0] f_calc = (mis_n == '0) ? start_q
                                           : base_q + (ADDR_W'(mis_n) << 4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      start_q    <= '0;
      base_q     <= '0;
      key_q      <= '0;
      odd_q      <= 1'b0;
      dvld_q     <= 1'b0;
      left_q     <= '0;
      seen_q     <= '0;
      rd_left_q  <= '0;
      rd_ptr_q   <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      unchecked  <= 1'b0;
      fault_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_chk_en) begin
              state     <= S_SCAN;
              start_q   <= req_addr;
              base_q    <= first_g;
              key_q     <= req_addr[KEY_LSB +: 4];
              odd_q     <= req_addr[4];
              left_q    <= g_init;
              seen_q    <= '0;
              rd_left_q <= b_init;
              rd_ptr_q  <= req_addr[5 +: TAG_AW];
              dvld_q    <= 1'b0;
            end else begin
              done       <= 1'b1;
              unchecked  <= 1'b1;
              fail       <= 1'b0;
              fault_addr <= '0;
            end
          end
        end
        S_SCAN: begin
          dvld_q <= mem_rd_en;
          if (mem_rd_en) begin
            rd_ptr_q  <= rd_ptr_q + TAG_AW'(1);
            rd_left_q <= rd_left_q - CNT_W'(1);
          end
          if (miss) begin
            state      <= S_IDLE;
            done       <= 1'b1;
            fail       <= 1'b1;
            unchecked  <= 1'b0;
            fault_addr <= f_calc;
            rd_left_q  <= '0;
            dvld_q     <= 1'b0;
          end else if (fin) begin
            state      <= S_IDLE;
            done       <= 1'b1;
            fail       <= 1'b0;
            unchecked  <= 1'b0;
            fault_addr <= '0;
          end else if (dvld_q) begin
            seen_q <= seen_q + take;
            left_q <= left_q - take;
            odd_q  <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_take_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_chk_en) |=> !req_ready);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_chk_en) |=> (done && unchecked && !fail && !mem_rd_en));

  assert_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + TAG_AW'(1)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(req_valid && !req_chk_en));

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(fail && unchecked));

  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (fault_addr == '0));
endmodule

// File: tb/tb_tag_granule_checker.sv
module tb_tag_granule_checker;
  localparam int ADDR_W = 64;
  localparam int SIZE_W = 12;
  localparam int TAG_AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SIZE_W-1:0] req_size_m1 = '0;
  logic req_chk_en = 1'b0;
  logic mem_rd_en;
  logic [TAG_AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic done, fail, unchecked;
  logic [ADDR_W-1:0] fault_addr;

  always #5 clk = ~clk;

  tag_granule_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_AW(TAG_AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size_m1(req_size_m1), .req_chk_en(req_chk_en),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .unchecked(unchecked), .fault_addr(fault_addr));

  logic [7:0] tmem [256];
  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= tmem[mem_addr];

  typedef struct {
    logic        fail;
    logic        unch;
    logic [63:0] fault;
    int          reads;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int rdcnt = 0;

  function automatic logic [63:0] ptr(input logic [3:0] key, input logic [55:0] low);
    return {4'h0, key, low};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [63:0] a, input int sz, input logic en, input string req);
    exp_t e;
    logic [63:0] first, last;
    int n;
    e.fail = 1'b0; e.unch = !en; e.fault = '0; e.req = req;
    first = {a[63:4], 4'b0};
    last  = a + 64'(sz);
    last  = {last[63:4], 4'b0};
    n = int'((last - first) >> 4) + 1;
    e.reads = en ? int'((last >> 5) - (first >> 5)) + 1 : 0;
    if (en) begin
      for (int g = 0; g < n; g++) begin
        logic [63:0] ga;
        logic [7:0] b;
        logic [3:0] t;
        ga = first + 64'(g) * 64'd16;
        b = tmem[ga[12:5]];
        t = ga[4] ? b[7:4] : b[3:0];
        if (t != a[59:56]) begin
          e.fail = 1'b1;
          e.fault = (g == 0) ? a : ga;
          e.reads = -1;
          break;
        end
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size_m1 = SIZE_W'(sz); req_chk_en = en;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 actual=unexpected done expected=none");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.req, " fail"}, 64'(fail), 64'(e.fail));
          chk({e.req, " unchecked"}, 64'(unchecked), 64'(e.unch));
          chk({e.req, " fault_addr"}, fault_addr, e.fault);
          if (e.reads >= 0) chk({e.req, " R11 reads"}, 64'(rdcnt), 64'(e.reads));
        end
        rdcnt = 0;
      end else if (mem_rd_en) rdcnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 rd_en after reset", 64'(mem_rd_en), 64'd0);

    tmem[8'h08] = 8'h33;
    send(ptr(4'h5, 56'h100), 15, 1'b0, "R2 bypass");
    settle();

    send(ptr(4'h5, 56'h100), 15, 1'b1, "R6 aligned single");
    settle();

    tmem[8'h08] = 8'h5A;
    send(ptr(4'h5, 56'h110), 15, 1'b1, "R12 odd start ignores low nibble");
    send(ptr(4'h5, 56'h100), 0, 1'b1, "R4 even granule reads low nibble");
    settle();

    tmem[8'h09] = 8'hA5;
    send(ptr(4'h5, 56'h120), 15, 1'b1, "R12 last even ignores high nibble");
    send(ptr(4'h5, 56'h120), 31, 1'b1, "R4 pair in one byte");
    settle();
    tmem[8'h09] = 8'h55;

    tmem[8'h0B] = 8'hA5;
    send(ptr(4'h5, 56'h138), 40, 1'b1, "R6 four granules three bytes");
    settle();

    tmem[8'h10] = 8'h5C;
    send(ptr(4'h5, 56'h208), 8, 1'b1, "R7 first granule fault");
    settle();

    tmem[8'h19] = 8'hCC;
    send(ptr(4'h5, 56'h304), 63, 1'b1, "R8 later granule fault");
    send(ptr(4'h5, 56'h308), 100, 1'b1, "R9 stop at first mismatch");
    settle();

    tmem[8'h20] = 8'hC5;
    send(ptr(4'h5, 56'h410), 0, 1'b1, "R4 odd start high nibble fault");
    settle();

    for (int i = 8'h30; i < 8'h34; i++) tmem[i] = 8'hAA;
    send(ptr(4'hA, 56'h600), 127, 1'b1, "R5 key bits select tag");
    send(ptr(4'hA, 56'h500), 0, 1'b1, "R5 key mismatch");
    settle();

    send(ptr(4'h5, 56'h700), 255, 1'b1, "R11 eight byte span");
    settle();

    tmem[8'h38] = 8'h00;
    send(ptr(4'h5, 56'h700), 31, 1'b0, "R1 bypass then checked");
    send(ptr(4'h5, 56'h700), 31, 1'b1, "R3 checked after bypass");
    settle();

    tmem[8'h48] = 8'h55;
    tmem[8'h49] = 8'h55;
    tmem[8'h4A] = 8'h5C;
    send(ptr(4'h5, 56'h91F), 65, 1'b1, "R8 fault in third byte");
    settle();

    repeat (4) @(negedge clk);
    chk("R1 idle at end", 64'(req_ready), 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule